// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block carries a small 32-bit processor core through its reset exception. A synchronous reset abandons any bus activity in progress and puts the control state into a known condition. The status word enters supervisor mode with tracing off and all interrupts masked. The vector base is zeroed and every memory-control enable is cleared. None of the interrupted work is resumed.

When reset is released, the sequencer requests the bus and waits for a grant. It then runs three word reads over a valid/ready read channel. The word at address 0 becomes the initial supervisor stack pointer. The word at address 4 becomes the program counter. The word at that program counter is the first instruction, and once it arrives a one-cycle start pulse hands control to execution.

Any fault before that point stops the core for good. A fault is either an access error reported on a read or a misaligned (odd) program counter. The core enters a halted state that only another reset can leave.

Top module: `boot_vector_seq`

## Requirements
- R1: While `rst` is high, `bus_req`, `rd_valid` and `core_start` are low. After a clock edge with `rst` high, `halted` is low. A reset in the middle of the sequence abandons it, and the next sequence starts again from the address-0 read.
- R2: After reset, `sr` equals 16'h2700: trace bit 15 = 0, supervisor bit 13 = 1, master bit 12 = 0, interrupt mask bits 10:8 = 3'b111. It keeps that value through the boot sequence.
- R3: After reset, `vbr` is 0 and every bit of `mem_en` is 0.
- R4: After reset is released, `bus_req` goes high. No read is issued (`rd_valid` low) while `bus_gnt` is low.
- R5: The first read is at address 0 and its data appears on `ssp`. The second read is at address 4 and its data appears on `pc`. The order is always address 0, then address 4.
- R6: A read completes only in a cycle with `rd_valid` and `rd_ready` both high. While the read waits for `rd_ready`, `rd_addr` holds steady.
- R7: The third read is at the loaded `pc`, and its data appears on `insn`. `core_start` is high for exactly one cycle, the cycle after that read completes. Afterwards `bus_req` is low.
- R8: If `rd_err` is high when any of the three reads completes, `halted` rises. No further read is issued and `core_start` never pulses.
- R9: A loaded `pc` with bit 0 set counts as an address error. `halted` rises and the instruction read is never issued.
- R10: Once high, `halted` stays high, with `bus_req` low, whatever the bus inputs do. Only a reset clears it, and the boot sequence then runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_gnt | input | 1 | Bus grant |
| rd_ready | input | 1 | Memory accepts/answers the current read |
| rd_data | input | DW | Read data |
| rd_err | input | 1 | Access error for the current read |
| bus_req | output | 1 | Bus request |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read address |
| sr | output | 16 | Status word |
| vbr | output | AW | Vector base |
| mem_en | output | MEMCTL_W | Memory-control enables |
| ssp | output | DW | Supervisor stack pointer |
| pc | output | DW | Program counter |
| insn | output | DW | First instruction word |
| core_start | output | 1 | One-cycle execution start pulse |
| halted | output | 1 | Fault-on-fault halt |

## Verification
A clean boot with distinct stack, counter and instruction values shows that each vector lands in its own register, in the required order. A delayed grant separates waiting for the bus from waiting for memory. An alternating ready shows that addresses hold through wait states. Errors injected at each of the three reads, together with an odd counter value, distinguish faults by where the sequence stops. A reset during a stalled read, and a reset out of the halted state, show that nothing carries over between sequences.

// File: rtl/boot_vector_seq.sv
module boot_vector_seq #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int MEMCTL_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_gnt,
  input  logic                rd_ready,
  input  logic [DW-1:0]       rd_data,
  input  logic                rd_err,
  output logic                bus_req,
  output logic                rd_valid,
  output logic [AW-1:0]       rd_addr,
  output logic [15:0]         sr,
  output logic [AW-1:0]       vbr,
  output logic [MEMCTL_W-1:0] mem_en,
  output logic [DW-1:0]       ssp,
  output logic [DW-1:0]       pc,
  output logic [DW-1:0]       insn,
  output logic                core_start,
  output logic                halted
);
  localparam logic [15:0]   SR_RESET = 16'h2700;
  localparam logic [AW-1:0] VEC_SP   = '0;
  localparam logic [AW-1:0] VEC_PC   = AW'(DW / 8);

  typedef enum logic [2:0] {ST_REQ, ST_SP, ST_PC, ST_FETCH, ST_RUN, ST_HALT} state_t;
  state_t state;

  logic busy, xfer;
  assign busy     = (state == ST_SP) || (state == ST_PC) || (state == ST_FETCH);
  assign bus_req  = ~rst & ((state == ST_REQ) | busy);
  assign rd_valid = ~rst & busy & bus_gnt;
  assign xfer     = rd_valid & rd_ready;
  assign halted   = (state == ST_HALT);

  always_comb begin
    case (state)
      ST_PC:    rd_addr = VEC_PC;
      ST_FETCH: rd_addr = AW'(pc);
      default:  rd_addr = VEC_SP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_REQ;
      sr         <= SR_RESET;
      vbr        <= '0;
      mem_en     <= '0;
      ssp        <= '0;
      pc         <= '0;
      insn       <= '0;
      core_start <= 1'b0;
    end else begin
      core_start <= 1'b0;
      case (state)
        ST_REQ: if (bus_gnt) state <= ST_SP;
        ST_SP: if (xfer) begin
          if (rd_err) state <= ST_HALT;
          else begin
            ssp   <= rd_data;
            state <= ST_PC;
          end
        end
        ST_PC: if (xfer) begin
          if (rd_err) state <= ST_HALT;
          else begin
            pc    <= rd_data;
            state <= rd_data[0] ? ST_HALT : ST_FETCH;
          end
        end
        ST_FETCH: if (xfer) begin
          if (rd_err) state <= ST_HALT;
          else begin
            insn       <= rd_data;
            core_start <= 1'b1;
            state      <= ST_RUN;
          end
        end
        default: state <= state;
      endcase
    end
  end

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R4
  valid_needs_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (bus_gnt && bus_req));

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> $stable(rd_addr));

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |=> !core_start);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!bus_req && !rd_valid && !core_start));

  // R2
  sr_init_chk: assert property (@(posedge clk) disable iff (rst)
    core_start |-> (sr == SR_RESET && vbr == '0 && mem_en == '0));
endmodule

// File: tb/boot_vector_seq_test.sv
module boot_vector_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_gnt = 1'b1;
  logic        rd_ready, rd_err;
  logic [31:0] rd_data;
  logic        bus_req, rd_valid, core_start, halted;
  logic [31:0] rd_addr, vbr, ssp, pc, insn;
  logic [15:0] sr;
  logic [1:0]  mem_en;

  logic [31:0] ssp_v = 32'h0000_8000, pc_v = 32'h0000_0400, insn_v = 32'h4E71_0000;
  logic        stall = 1'b0, rdy_tog = 1'b0, err_en = 1'b0;
  logic [31:0] err_addr = 32'h0;

  int checks = 0, fails = 0;
  int nlog = 0, starts = 0, viol = 0, unstable = 0;
  logic [31:0] log_a [0:7];
  logic        was_wait = 1'b0;
  logic [31:0] wait_addr = 32'h0;

  always #10 clk = ~clk;

  assign rd_ready = stall ? rdy_tog : 1'b1;
  assign rd_err   = err_en && (rd_addr == err_addr);
  assign rd_data  = (rd_addr == 32'h0) ? ssp_v :
                    (rd_addr == 32'h4) ? pc_v  :
                    (rd_addr == pc_v)  ? insn_v : 32'hDEAD_BEEF;

  always @(posedge clk) #2 rdy_tog = ~rdy_tog;

  boot_vector_seq uut (
    .clk(clk), .rst(rst), .bus_gnt(bus_gnt), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_err(rd_err), .bus_req(bus_req), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .sr(sr), .vbr(vbr), .mem_en(mem_en), .ssp(ssp), .pc(pc), .insn(insn),
    .core_start(core_start), .halted(halted)
  );

  always @(negedge clk) begin
    if (rd_valid && !bus_gnt) viol++;
    if (was_wait && rd_valid && rd_addr != wait_addr) unstable++;
    was_wait  = rd_valid && !rd_ready;
    wait_addr = rd_addr;
    if (rd_valid && rd_ready && nlog < 8) begin
      log_a[nlog] = rd_addr;
      nlog++;
    end
    if (core_start) starts++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #2 rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 idle during reset", {bus_req, rd_valid, core_start, halted}, 4'b0000);
    @(posedge clk); #2 rst = 1'b0;
    nlog = 0; starts = 0; viol = 0; unstable = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (core_start || halted) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_clean_boot();
    ssp_v = 32'h0000_8000; pc_v = 32'h0000_0400; insn_v = 32'h4E71_0000;
    err_en = 0; stall = 0; bus_gnt = 1;
    do_reset();
    @(negedge clk);
    check("R2 status word", {16'h0, sr}, 32'h0000_2700);
    check("R3 vbr zero", vbr, 32'h0);
    check("R3 mem enables off", {30'h0, mem_en}, 32'h0);
    wait_done();
    check("R5 read count", nlog, 3);
    check("R5 first addr", log_a[0], 32'h0);
    check("R5 second addr", log_a[1], 32'h4);
    check("R7 fetch addr", log_a[2], 32'h400);
    check("R5 ssp", ssp, 32'h0000_8000);
    check("R5 pc", pc, 32'h0000_0400);
    check("R7 insn", insn, 32'h4E71_0000);
    check("R7 start pulses", starts, 1);
    check("R7 bus released", bus_req, 1'b0);
    check("R2 status kept", {16'h0, sr}, 32'h0000_2700);
    check("R10 not halted", halted, 1'b0);
  endtask

  task automatic t_late_grant_stall();
    ssp_v = 32'h1234_5670; pc_v = 32'h0000_2000; insn_v = 32'hCAFE_F00D;
    err_en = 0; stall = 1; bus_gnt = 0;
    do_reset();
    repeat (4) @(negedge clk);
    check("R4 request raised", bus_req, 1'b1);
    check("R4 no read without grant", nlog, 0);
    @(posedge clk); #2 bus_gnt = 1;
    wait_done();
    check("R4 valid only with grant", viol, 0);
    check("R6 addr stable in wait", unstable, 0);
    check("R6 three reads", nlog, 3);
    check("R5 ssp stalled", ssp, 32'h1234_5670);
    check("R7 insn stalled", insn, 32'hCAFE_F00D);
    check("R7 one pulse", starts, 1);
    stall = 0;
  endtask

  task automatic t_err_at(input logic [31:0] a, input int exp_reads, input string req);
    ssp_v = 32'h0000_8000; pc_v = 32'h0000_0400;
    err_en = 1; err_addr = a; stall = 0; bus_gnt = 1;
    do_reset();
    wait_done();
    check(req, halted, 1'b1);
    check("R8 reads before halt", nlog, exp_reads);
    check("R8 no start", starts, 0);
    err_en = 0;
  endtask

  task automatic t_odd_pc();
    pc_v = 32'h0000_0401; err_en = 0; stall = 0; bus_gnt = 1;
    do_reset();
    wait_done();
    check("R9 halted on odd pc", halted, 1'b1);
    check("R9 no fetch", nlog, 2);
    check("R9 no start", starts, 0);
    pc_v = 32'h0000_0400;
  endtask

  task automatic t_halt_sticky();
    repeat (6) @(negedge clk);
    check("R10 still halted", halted, 1'b1);
    check("R10 bus idle", {bus_req, rd_valid}, 2'b00);
    check("R10 no reads", nlog, 2);
    do_reset();
    @(negedge clk);
    check("R10 reset clears halt", halted, 1'b0);
    wait_done();
    check("R10 reboot starts", starts, 1);
    check("R10 reboot pc", pc, 32'h0000_0400);
  endtask

  task automatic t_abort();
    ssp_v = 32'h0000_8000; pc_v = 32'h0000_0600; insn_v = 32'h1111_2222;
    err_en = 0; stall = 1; bus_gnt = 1;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (nlog >= 1) break;
    end
    do_reset();
    check("R1 abort clears start", starts, 0);
    wait_done();
    check("R1 restart at addr 0", log_a[0], 32'h0);
    check("R1 restart completes", starts, 1);
    stall = 0;
  endtask

  initial begin
    fork
      begin
        t_clean_boot();
        t_late_grant_stall();
        t_err_at(32'h0, 1, "R8 halt on sp error");
        t_err_at(32'h4, 2, "R8 halt on pc error");
        t_err_at(32'h400, 3, "R8 halt on fetch error");
        t_odd_pc();
        t_halt_sticky();
        t_abort();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule